// File: doc/BRIEF.md
# SPI Slave SRAM Command Interface

This block is the serial front end of a byte-wide static memory. An SPI master selects it by pulling chip select low. The block then takes a command byte and, when the command needs one, a two-byte address. After that it streams data bytes into or out of the array. An internal address counter steps once per byte and wraps either within a 64-byte page or across the whole array, as a status bit selects.

Writes are guarded in two ways. A write-enable latch must be set by its own command first. A two-bit protection field in the status register then fences off none, the top quarter, the top half or all of the array. An unrecognised command byte makes the block deaf and mute for the rest of that select cycle.

The SPI pins are oversampled by a system clock (`clk`), so SCK must run well below that clock. The serial output is reported as a data bit plus an enable. The pad is expected to float whenever the enable is low.

Top module: `spi_sram_if`

## Requirements
- R1: SPI modes 0 and 3 both work. The input bit is taken on each rising SCK edge, and the output bit changes only after a falling SCK edge. Bytes travel most significant bit first in both directions.
- R2: The first byte of every select cycle is the command. Codes: 0x06 set write enable, 0x04 clear write enable, 0x05 read status, 0x01 write status, 0x03 read array, 0x02 write array.
- R3: Read and write send the address as two bytes, high byte first. Only the low ADDR_W bits are used and higher bits are ignored. Each further data byte moves to the next address.
- R4: A data byte of a write command is stored only while the write enable latch is set.
- R5: Status bit 5 at 1 makes the counter wrap inside its 2^PAGE_W-byte page. At 0 the counter runs on to the next page and wraps from the top address to 0.
- R6: Status bits 3:2 select write protection: 00 none, 01 top quarter, 10 top half, 11 whole array. A write byte aimed at a protected address leaves memory unchanged.
- R7: The set-enable command sets the latch, which reads back as status bit 1. The clear-enable command clears it, so later writes are dropped.
- R8: When chip select rises after a write that stored or tried to store at least one byte with the latch set, or after an accepted status write, the latch clears.
- R9: Read status returns {00, wrap bit, 0, protect bits, latch, 0} and repeats it for every byte. Write status updates bits 5 and 3:2 from its first data byte, only when the latch is set.
- R10: After an unknown command, further input is not decoded and the output stays disabled until chip select goes high and low again.
- R11: The output enable is low while chip select is high, and during every phase other than read array and read status data.
- R12: After reset the status register reads 0x00 and the output enable is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock used to oversample the SPI pins |
| rst_n | input | 1 | Active-low asynchronous reset |
| spi_cs_n | input | 1 | Chip select, active low |
| spi_sck | input | 1 | Serial clock from the master |
| spi_mosi | input | 1 | Serial data into the block |
| spi_miso | output | 1 | Serial data out of the block (0 when not enabled) |
| spi_miso_oe | output | 1 | High when spi_miso must be driven onto the pad |

## Verification
The bench builds the block with ADDR_W = 9 and PAGE_W = 6, which gives a 512-byte array of eight 64-byte pages. At that size, one burst fills the whole array, so every later readback is checked against known contents. The top-to-zero wrap and each protection quarter can then be reached in a few bytes. A page boundary sits at both address 63 and address 127, so the page-wrap case is covered for reads and for writes. SYNC_STAGES = 2 with four system clocks per SCK half-period keeps the full run inside the cycle budget.

// File: rtl/spi_sram_pkg.sv
`timescale 1ns/1ps
package spi_sram_pkg;

   // command codes
   localparam logic [7:0] CMD_SET_WE  = 8'h06;
   localparam logic [7:0] CMD_CLR_WE  = 8'h04;
   localparam logic [7:0] CMD_RD_STAT = 8'h05;
   localparam logic [7:0] CMD_WR_STAT = 8'h01;
   localparam logic [7:0] CMD_RD_MEM  = 8'h03;
   localparam logic [7:0] CMD_WR_MEM  = 8'h02;

   // status byte field positions
   localparam int STAT_WRAP = 5;
   localparam int STAT_PR_H = 3;
   localparam int STAT_PR_L = 2;
   localparam int STAT_WEL  = 1;

   typedef enum logic [3:0] {
      PH_CMD,
      PH_ADR_H,
      PH_ADR_L,
      PH_MEM_RD,
      PH_MEM_WR,
      PH_STAT_RD,
      PH_STAT_WR,
      PH_PARK,
      PH_MUTE
   } phase_t;

endpackage

// File: rtl/spi_sram_sync.sv
`timescale 1ns/1ps
module spi_sram_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic cs_n_in,
   input  logic sck_in,
   input  logic sdi_in,
   output logic sck_up,
   output logic sck_dn,
   output logic sel_start,
   output logic sel_end,
   output logic sel_idle,
   output logic sdi
);
   localparam int W = 3;
   localparam logic [W-1:0] RST_V = 3'b100;

   logic [W-1:0] chain [STAGES];
   logic         sck_prev;
   logic         cs_prev;

   genvar k;
   generate
      for (k = 0; k < STAGES; k++) begin : g_stage
         if (k == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) chain[k] <= RST_V;
               else        chain[k] <= {cs_n_in, sck_in, sdi_in};
            end
         end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) chain[k] <= RST_V;
               else        chain[k] <= chain[k-1];
            end
         end
      end
   endgenerate

   logic [W-1:0] synced;
   assign synced = chain[STAGES-1];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sck_prev <= 1'b0;
         cs_prev  <= 1'b1;
      end else begin
         sck_prev <= synced[1];
         cs_prev  <= synced[2];
      end
   end

   assign sck_up    =  synced[1] & ~sck_prev;
   assign sck_dn    = ~synced[1] &  sck_prev;
   assign sel_start = ~synced[2] &  cs_prev;
   assign sel_end   =  synced[2] & ~cs_prev;
   assign sel_idle  =  synced[2];
   assign sdi       =  synced[0];

endmodule

// File: rtl/spi_sram_addr.sv
`timescale 1ns/1ps
module spi_sram_addr #(
   parameter int ADDR_W = 11,
   parameter int PAGE_W = 6
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic [ADDR_W-1:0] load_val,
   input  logic              step,
   input  logic              page_wrap,
   input  logic [1:0]        prot_sel,
   output logic [ADDR_W-1:0] cur,
   output logic [ADDR_W-1:0] nxt,
   output logic              locked
);
   logic [ADDR_W-1:0] nxt_page;
   logic [ADDR_W-1:0] nxt_flat;

   assign nxt_flat = cur + 1'b1;

   generate
      if (PAGE_W >= ADDR_W) begin : g_page_is_array
         assign nxt_page = nxt_flat;
      end else begin : g_page_split
         logic [PAGE_W-1:0] low_inc;
         assign low_inc  = cur[PAGE_W-1:0] + 1'b1;
         assign nxt_page = {cur[ADDR_W-1:PAGE_W], low_inc};
      end
   endgenerate

   assign nxt = page_wrap ? nxt_page : nxt_flat;

   always_comb begin
      unique case (prot_sel)
         2'b00:   locked = 1'b0;
         2'b01:   locked = cur[ADDR_W-1] & cur[ADDR_W-2];
         2'b10:   locked = cur[ADDR_W-1];
         default: locked = 1'b1;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    cur <= '0;
      else if (load) cur <= load_val;
      else if (step) cur <= nxt;
   end

   // R5: flat mode moves by exactly one, wrapping at the top
   a_r5_flat_step: assert property (@(posedge clk) disable iff (!rst_n)
      (step && !load && !page_wrap) |=> (cur == $past(cur) + 1'b1));

   generate
      if (PAGE_W < ADDR_W) begin : g_page_chk
         // R5: page mode never leaves the current page
         a_r5_page_hold: assert property (@(posedge clk) disable iff (!rst_n)
            (step && !load && page_wrap) |=>
               (cur[ADDR_W-1:PAGE_W] == $past(cur[ADDR_W-1:PAGE_W])));
      end
   endgenerate

endmodule

// File: rtl/spi_sram_array.sv
`timescale 1ns/1ps
module spi_sram_array #(
   parameter int ADDR_W = 11
) (
   input  logic              clk,
   input  logic              we,
   input  logic [ADDR_W-1:0] waddr,
   input  logic [7:0]        wdata,
   input  logic [ADDR_W-1:0] raddr,
   output logic [7:0]        rdata
);
   localparam int DEPTH = 1 << ADDR_W;

   logic [7:0] cells [DEPTH];

   always_ff @(posedge clk) begin
      if (we) cells[waddr] <= wdata;
   end

   assign rdata = cells[raddr];

endmodule

// File: rtl/spi_sram_ctrl.sv
`timescale 1ns/1ps
module spi_sram_ctrl
   import spi_sram_pkg::*;
#(
   parameter int ADDR_W = 11
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sck_up,
   input  logic              sck_dn,
   input  logic              sel_start,
   input  logic              sel_end,
   input  logic              sel_idle,
   input  logic              sdi,
   input  logic [ADDR_W-1:0] adr_nxt,
   input  logic              adr_locked,
   input  logic [7:0]        mem_rdata,
   output logic [ADDR_W-1:0] mem_raddr,
   output logic              mem_we,
   output logic [7:0]        mem_wdata,
   output logic              adr_load,
   output logic [ADDR_W-1:0] adr_load_val,
   output logic              adr_step,
   output logic              page_wrap,
   output logic [1:0]        prot_sel,
   output logic              wel,
   output logic              so,
   output logic              so_en
);
   localparam int HI_W = ADDR_W - 8;

   phase_t          ph;
   logic [2:0]      bcnt;
   logic [6:0]      rx_q;
   logic [HI_W-1:0] adr_hi;
   logic [7:0]      tx_q;
   logic            wr_done;
   logic            is_write;

   logic       live;
   logic [7:0] rx_byte;
   logic       byte_end;
   logic       shifting;
   logic [7:0] stat_byte;

   assign live      = !sel_idle && !sel_start && !sel_end;
   assign rx_byte   = {rx_q, sdi};
   assign shifting  = (ph != PH_PARK) && (ph != PH_MUTE);
   assign byte_end  = live && sck_up && shifting && (bcnt == 3'd7);
   assign stat_byte = {2'b00, page_wrap, 1'b0, prot_sel, wel, 1'b0};

   assign adr_load_val = {adr_hi, rx_byte};
   assign adr_load     = byte_end && (ph == PH_ADR_L);
   assign adr_step     = byte_end && ((ph == PH_MEM_RD) || (ph == PH_MEM_WR));
   assign mem_raddr    = (ph == PH_ADR_L) ? adr_load_val : adr_nxt;
   assign mem_we       = byte_end && (ph == PH_MEM_WR) && wel && !adr_locked;
   assign mem_wdata    = rx_byte;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ph        <= PH_CMD;
         bcnt      <= '0;
         rx_q      <= '0;
         adr_hi    <= '0;
         tx_q      <= '0;
         wr_done   <= 1'b0;
         is_write  <= 1'b0;
         wel       <= 1'b0;
         page_wrap <= 1'b0;
         prot_sel  <= 2'b00;
         so        <= 1'b0;
         so_en     <= 1'b0;
      end else if (sel_start || sel_end) begin
         ph      <= PH_CMD;
         bcnt    <= '0;
         so_en   <= 1'b0;
         wr_done <= 1'b0;
         if (sel_end && wr_done) wel <= 1'b0;
      end else if (live) begin
         if (sck_up && shifting) begin
            bcnt <= bcnt + 3'd1;
            rx_q <= rx_byte[6:0];
         end
         if (byte_end) begin
            unique case (ph)
               PH_CMD: begin
                  unique case (rx_byte)
                     CMD_SET_WE:  begin wel <= 1'b1; ph <= PH_PARK; end
                     CMD_CLR_WE:  begin wel <= 1'b0; ph <= PH_PARK; end
                     CMD_RD_STAT: begin tx_q <= stat_byte; ph <= PH_STAT_RD; end
                     CMD_WR_STAT: ph <= PH_STAT_WR;
                     CMD_RD_MEM:  begin is_write <= 1'b0; ph <= PH_ADR_H; end
                     CMD_WR_MEM:  begin is_write <= 1'b1; ph <= PH_ADR_H; end
                     default:     ph <= PH_MUTE;
                  endcase
               end
               PH_ADR_H: begin
                  adr_hi <= rx_byte[HI_W-1:0];
                  ph     <= PH_ADR_L;
               end
               PH_ADR_L: begin
                  tx_q <= mem_rdata;
                  ph   <= is_write ? PH_MEM_WR : PH_MEM_RD;
               end
               PH_MEM_RD:  tx_q <= mem_rdata;
               PH_STAT_RD: tx_q <= stat_byte;
               PH_MEM_WR:  if (wel) wr_done <= 1'b1;
               PH_STAT_WR: begin
                  if (wel) begin
                     page_wrap <= rx_byte[STAT_WRAP];
                     prot_sel  <= rx_byte[STAT_PR_H:STAT_PR_L];
                     wr_done   <= 1'b1;
                  end
                  ph <= PH_PARK;
               end
               default: ph <= ph;
            endcase
         end
         if (sck_dn && ((ph == PH_MEM_RD) || (ph == PH_STAT_RD))) begin
            so    <= tx_q[3'd7 - bcnt];
            so_en <= 1'b1;
         end
      end
   end

   // R11: output enable falls once chip select has risen
   a_r11_quiet_after_sel: assert property (@(posedge clk) disable iff (!rst_n)
      sel_end |=> !so_en);

   // R10: no drive while muted by an unknown command
   a_r10_mute_silent: assert property (@(posedge clk) disable iff (!rst_n)
      (ph == PH_MUTE) |-> !so_en);

   // R7: clear-enable command drops the latch
   a_r7_clear_we: assert property (@(posedge clk) disable iff (!rst_n)
      (byte_end && (ph == PH_CMD) && (rx_byte == CMD_CLR_WE)) |=> !wel);

   // R1: output bit moves only after a falling clock edge
   a_r1_so_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
      !sck_dn |=> $stable(so));

   // R8: a completed write leaves the latch clear at deselect
   a_r8_auto_clear: assert property (@(posedge clk) disable iff (!rst_n)
      (sel_end && wr_done) |=> !wel);

endmodule

// File: rtl/spi_sram_if.sv
`timescale 1ns/1ps
module spi_sram_if #(
   parameter int ADDR_W      = 11,
   parameter int PAGE_W      = 6,
   parameter int SYNC_STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic spi_cs_n,
   input  logic spi_sck,
   input  logic spi_mosi,
   output logic spi_miso,
   output logic spi_miso_oe
);
   generate
      if (ADDR_W < 9 || ADDR_W > 15) begin : g_bad_addr_w
         $error("spi_sram_if: ADDR_W must lie in 9..15");
      end
      if (PAGE_W < 1 || PAGE_W > ADDR_W) begin : g_bad_page_w
         $error("spi_sram_if: PAGE_W must lie in 1..ADDR_W");
      end
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("spi_sram_if: SYNC_STAGES must be at least 2");
      end
   endgenerate

   logic sck_up, sck_dn, sel_start, sel_end, sel_idle, sdi;
   logic [ADDR_W-1:0] cur_adr, nxt_adr, load_val, mem_raddr;
   logic adr_load, adr_step, adr_locked, page_wrap, wel;
   logic [1:0] prot_sel;
   logic mem_we;
   logic [7:0] mem_wdata, mem_rdata;
   logic so, so_en;

   spi_sram_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk       (clk),
      .rst_n     (rst_n),
      .cs_n_in   (spi_cs_n),
      .sck_in    (spi_sck),
      .sdi_in    (spi_mosi),
      .sck_up    (sck_up),
      .sck_dn    (sck_dn),
      .sel_start (sel_start),
      .sel_end   (sel_end),
      .sel_idle  (sel_idle),
      .sdi       (sdi)
   );

   spi_sram_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
      .clk          (clk),
      .rst_n        (rst_n),
      .sck_up       (sck_up),
      .sck_dn       (sck_dn),
      .sel_start    (sel_start),
      .sel_end      (sel_end),
      .sel_idle     (sel_idle),
      .sdi          (sdi),
      .adr_nxt      (nxt_adr),
      .adr_locked   (adr_locked),
      .mem_rdata    (mem_rdata),
      .mem_raddr    (mem_raddr),
      .mem_we       (mem_we),
      .mem_wdata    (mem_wdata),
      .adr_load     (adr_load),
      .adr_load_val (load_val),
      .adr_step     (adr_step),
      .page_wrap    (page_wrap),
      .prot_sel     (prot_sel),
      .wel          (wel),
      .so           (so),
      .so_en        (so_en)
   );

   spi_sram_addr #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W)) u_addr (
      .clk       (clk),
      .rst_n     (rst_n),
      .load      (adr_load),
      .load_val  (load_val),
      .step      (adr_step),
      .page_wrap (page_wrap),
      .prot_sel  (prot_sel),
      .cur       (cur_adr),
      .nxt       (nxt_adr),
      .locked    (adr_locked)
   );

   spi_sram_array #(.ADDR_W(ADDR_W)) u_array (
      .clk   (clk),
      .we    (mem_we),
      .waddr (cur_adr),
      .wdata (mem_wdata),
      .raddr (mem_raddr),
      .rdata (mem_rdata)
   );

   assign spi_miso_oe = so_en & ~sel_idle;
   assign spi_miso    = so & spi_miso_oe;

   // R6: no store lands inside the protected region
   a_r6_no_protected_store: assert property (@(posedge clk) disable iff (!rst_n)
      mem_we |-> !((prot_sel == 2'b11) ||
                   ((prot_sel == 2'b10) && cur_adr[ADDR_W-1]) ||
                   ((prot_sel == 2'b01) && cur_adr[ADDR_W-1] && cur_adr[ADDR_W-2])));

   // R4: a store needs the write enable latch
   a_r4_store_needs_wel: assert property (@(posedge clk) disable iff (!rst_n)
      mem_we |-> wel);

   // R11: pad enable low while deselected
   a_r11_idle_no_drive: assert property (@(posedge clk) disable iff (!rst_n)
      (sel_idle && $past(sel_idle)) |-> !spi_miso_oe);

endmodule

// File: tb/spi_sram_if_test.sv
`timescale 1ns/1ps
module spi_sram_if_test;
   localparam int AW    = 9;
   localparam int PW    = 6;
   localparam int DEPTH = 1 << AW;
   localparam int H     = 4;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic cs_n = 1'b1;
   logic sck = 1'b0;
   logic mosi = 1'b0;
   logic miso, miso_oe;

   always #2.5 clk = ~clk;

   spi_sram_if #(.ADDR_W(AW), .PAGE_W(PW), .SYNC_STAGES(2)) uut (
      .clk         (clk),
      .rst_n       (rst_n),
      .spi_cs_n    (cs_n),
      .spi_sck     (sck),
      .spi_mosi    (mosi),
      .spi_miso    (miso),
      .spi_miso_oe (miso_oe)
   );

   logic [7:0] m [DEPTH];
   bit   mwel, mpg;
   bit [1:0] mbp;
   bit   m3;
   int   checks = 0;
   int   errors = 0;
   bit   done = 0;

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic tick(input int n);
      repeat (n) @(negedge clk);
   endtask

   function automatic bit f_prot(input int a, input bit [1:0] bp);
      bit [AW-1:0] x = AW'(a);
      case (bp)
         2'b00:   return 1'b0;
         2'b01:   return x[AW-1] & x[AW-2];
         2'b10:   return x[AW-1];
         default: return 1'b1;
      endcase
   endfunction

   function automatic int f_nxt(input int a);
      if (mpg) return (a & ~((1 << PW) - 1)) | ((a + 1) & ((1 << PW) - 1));
      return (a + 1) % DEPTH;
   endfunction

   function automatic logic [7:0] f_stat();
      return {2'b00, mpg, 1'b0, mbp, mwel, 1'b0};
   endfunction

   task automatic tx_begin(input bit mode3);
      m3  = mode3;
      sck = mode3;
      tick(H);
      cs_n = 1'b0;
      tick(H);
   endtask

   task automatic tx_end();
      tick(H);
      cs_n = 1'b1;
      tick(2 * H);
   endtask

   task automatic xbyte(input logic [7:0] d, output logic [7:0] q, output int oe_cnt);
      oe_cnt = 0;
      for (int i = 7; i >= 0; i--) begin
         if (m3) sck = 1'b0;
         mosi = d[i];
         tick(H);
         q[i] = miso;
         if (miso_oe) oe_cnt++;
         sck = 1'b1;
         tick(H);
         if (!m3) sck = 1'b0;
      end
   endtask

   function automatic logic [7:0] hi_byte(input int a);
      logic [7:0] r = 8'($urandom);
      logic [7:0] msk = 8'((1 << (AW - 8)) - 1);
      return (r & ~msk) | (8'(a >> 8) & msk);
   endfunction

   task automatic cmd_only(input logic [7:0] op, input bit mode3);
      logic [7:0] q; int oc;
      tx_begin(mode3);
      xbyte(op, q, oc);
      tx_end();
      if (op == 8'h06) mwel = 1'b1;
      if (op == 8'h04) mwel = 1'b0;
   endtask

   task automatic rd_status(input string req);
      logic [7:0] q; int oc;
      tx_begin($urandom % 2);
      xbyte(8'h05, q, oc);
      for (int k = 0; k < 2; k++) begin
         xbyte(8'h00, q, oc);
         chk(q == f_stat() && oc == 8, req, q, f_stat());
      end
      tx_end();
   endtask

   task automatic wr_status(input logic [7:0] v);
      logic [7:0] q; int oc;
      tx_begin($urandom % 2);
      xbyte(8'h01, q, oc);
      xbyte(v, q, oc);
      tx_end();
      if (mwel) begin
         mpg  = v[5];
         mbp  = v[3:2];
         mwel = 1'b0;
      end
   endtask

   task automatic do_write(input int a, input int n, input bit mode3);
      logic [7:0] q, d; int oc, tot, ad;
      bit wrote = 0;
      ad  = a % DEPTH;
      tot = 0;
      tx_begin(mode3);
      xbyte(8'h02, q, oc); tot += oc;
      xbyte(hi_byte(ad), q, oc); tot += oc;
      xbyte(8'(ad), q, oc); tot += oc;
      for (int k = 0; k < n; k++) begin
         d = 8'($urandom);
         xbyte(d, q, oc); tot += oc;
         if (mwel) begin
            wrote = 1;
            if (!f_prot(ad, mbp)) m[ad] = d;
         end
         ad = f_nxt(ad);
      end
      tx_end();
      // R11: no drive at any point of a write
      chk(tot == 0 && miso_oe == 1'b0, "R11", tot, 0);
      if (wrote) mwel = 1'b0;
   endtask

   task automatic do_read(input int a, input int n, input bit mode3, input string req);
      logic [7:0] q; int oc, ad;
      ad = a % DEPTH;
      tx_begin(mode3);
      xbyte(8'h03, q, oc);
      xbyte(hi_byte(ad), q, oc);
      xbyte(8'(ad), q, oc);
      for (int k = 0; k < n; k++) begin
         xbyte(8'h00, q, oc);
         chk(q == m[ad] && oc == 8, req, q, m[ad]);
         ad = f_nxt(ad);
      end
      tx_end();
      chk(miso_oe == 1'b0, "R11", miso_oe, 0);
   endtask

   initial begin
      repeat (190000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog actual=running expected=finished");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      logic [7:0] q; int oc;
      void'($urandom(32'd2024));
      mwel = 0; mpg = 0; mbp = 0;
      tick(5);
      rst_n = 1'b1;
      tick(4);

      // R12 / R11: reset state
      chk(miso_oe == 1'b0, "R12", miso_oe, 0);
      rd_status("R12");

      // R7: latch visible in status
      cmd_only(8'h06, 1'b0);
      rd_status("R7");

      // fill whole array, then R8 auto clear
      do_write(0, DEPTH, 1'b0);
      rd_status("R8");

      // R3 / R1: reads in both modes
      do_read(0, 20, 1'b0, "R3");
      do_read(300, 10, 1'b1, "R1");
      // R5: flat wrap from top to zero
      do_read(DEPTH - 7, 12, 1'b1, "R5");

      // R4: write without latch is dropped
      do_write(100, 4, 1'b0);
      do_read(100, 4, 1'b0, "R4");

      // R7: clear-enable blocks writes
      cmd_only(8'h06, 1'b1);
      cmd_only(8'h04, 1'b0);
      do_write(200, 3, 1'b1);
      do_read(200, 3, 1'b0, "R7");

      // R9: status write with latch selects page wrap
      cmd_only(8'h06, 1'b0);
      wr_status(8'h20);
      rd_status("R9");
      // R5: page wrap on read and write
      do_read(60, 8, 1'b0, "R5");
      cmd_only(8'h06, 1'b0);
      do_write(125, 6, 1'b1);
      do_read(120, 12, 1'b0, "R5");

      // R9: status write without latch is ignored
      wr_status(8'h0C);
      rd_status("R9");

      // R6: each protection setting
      for (int bp = 1; bp < 4; bp++) begin
         cmd_only(8'h06, 1'b0);
         wr_status(8'(32'h20 | (bp << 2)));
         rd_status("R6");
         for (int j = 0; j < 4; j++) begin
            cmd_only(8'h06, 1'b0);
            do_write(j * 128 + 30, 3, j[0]);
            do_read(j * 128 + 30, 3, 1'b0, "R6");
         end
      end

      // R10: unknown command mutes the rest of the cycle
      tx_begin(1'b0);
      xbyte(8'hAB, q, oc);
      xbyte(8'h06, q, oc);
      xbyte(8'h03, q, oc);
      chk(miso_oe == 1'b0, "R10", miso_oe, 0);
      xbyte(8'h00, q, oc);
      chk(oc == 0, "R10", oc, 0);
      tx_end();
      rd_status("R10");
      // R2: next select cycle decodes a command again
      do_read(40, 2, 1'b1, "R2");

      // constrained random traffic
      cmd_only(8'h06, 1'b0);
      wr_status(8'h00);
      for (int it = 0; it < 40; it++) begin
         int k = $urandom % 5;
         int a = $urandom % DEPTH;
         int n = 1 + $urandom % 10;
         bit md = $urandom % 2;
         case (k)
            0: cmd_only(8'h06, md);
            1: do_write(a, n, md);
            2: do_read(a, n, md, "R3");
            3: begin
               wr_status(8'($urandom));
               rd_status("R9");
            end
            default: begin
               cmd_only(8'h06, md);
               do_write(a, n, md);
               do_read(a, n, ~md, "R4");
            end
         endcase
      end

      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule